// File: doc/BRIEF.md
# Predicated Branch and Stack Sequencer

This block is the sequencing part of a small 16-bit machine. It owns the program counter, the stack pointer, two condition flags (A and B) and the interrupt-enable bit. For each two-word instruction handed to it on `start`, it first evaluates the predicate bits of the first word. An instruction that fails its predicate, or that belongs to any class other than control flow, only moves the program counter forward by two words.

A control-flow instruction gets its target from an external register file (through `rf_sel`/`rf_val`) or from a stack pop. It can push the return address, can jump to an absolute or a relative target, and can raise a software interrupt that vectors to address 0. It can also rewrite the interrupt enable. Stack traffic goes through a single-port word memory interface, one access per cycle. Read data is returned one cycle after the request. A small state machine orders the accesses and signals the end of each instruction with a one-cycle `done` pulse. The next `start` is given only after that pulse.

Top module: `branch_stack_unit`

## Requirements
- R1: For as long as `rst_n` is low, and after it is released, `pc`, `sp`, `flags` and `int_en` read 0, `done` is low and `mem_req` is low.
- R2: `flag_we[0]` loads `flag_wd[0]` into flag A and `flag_we[1]` loads `flag_wd[1]` into flag B, each independently. The new value shows on `flags` (bit 0 = A, bit 1 = B) after the next clock edge.
- R3: On the first word, bit 15 set requires flag A to equal bit 13, and bit 14 set requires flag B to equal bit 12. If any enabled test fails, the only effect is `pc` + 2: no memory access, and `sp` and `int_en` are unchanged.
- R4: An instruction whose first-word bits [11:8] are not 4 (not control flow) only adds 2 to `pc`.
- R5: Without a pop, the target is the register selected by second-word bits [15:11], presented on `rf_sel`. Index 31 reads the current `pc` and index 30 reads the current `sp` instead of `rf_val`.
- R6: First-word bit 7 selects a relative jump, where the new `pc` is the old `pc` plus the target modulo 2^16. Otherwise the target is loaded into `pc` directly.
- R7: First-word bit 6 pushes: it writes the old `pc` + 2 to memory at `sp`, then decrements `sp`.
- R8: First-word bit 5 pops: it increments `sp`, then reads the target from memory at the new `sp`. When a pop and a push occur together, the pop comes first.
- R9: When first-word bit 4 is set and `int_en` is 1, the instruction pushes if bit 6 is set and then sets `pc` to 0, with no pop and no register or relative target. When `int_en` is 0, bit 4 has no effect and the jump runs normally.
- R10: First-word bit 3 copies bit 2 into `int_en` when the instruction completes, on both the interrupt path and the jump path.
- R11: `done` is a single-cycle pulse. It comes 1 cycle after `start` when there are no stack accesses, plus 2 cycles for a pop and 1 for a push. `pc`, `sp` and `int_en` settle by the edge that ends the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin one instruction (only while idle) |
| instr_hi | input | 16 | First instruction word (predicates, class, control bits) |
| instr_lo | input | 16 | Second instruction word (source register index) |
| rf_sel | output | 5 | Register file read index |
| rf_val | input | 16 | Register file read data for `rf_sel` |
| flag_we | input | 2 | Per-flag write enable |
| flag_wd | input | 2 | Per-flag write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| done | output | 1 | Instruction complete pulse |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| flags | output | 2 | Flag B (bit 1) and flag A (bit 0) |
| int_en | output | 1 | Interrupt enable |

## Verification
The assertions assume that `start` arrives only while the sequencer is idle, that is, after the previous `done` pulse. They also assume that memory read data follows a read request by exactly one cycle. The stimulus keeps to both: every instruction is issued from a task that waits for `done` and one more cycle. The modelled memory answers each read at the next clock edge. Random first words are biased toward the control-flow class, with random predicate bits and flag writes, so the skip, interrupt, pop and push paths all run many times. Directed cases cover register indices 30 and 31, relative wrap, and interrupt with the enable off.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POP_REQ,
    ST_POP_CAP,
    ST_PUSH,
    ST_COMMIT
  } seq_state_t;

  typedef struct packed {
    logic skip;
    logic is_ctl;
    logic rel;
    logic push;
    logic pop;
    logic swi;
    logic ie_wr;
    logic ie_val;
  } ctl_dec_t;

  // first-word field positions
  localparam int PA_EN   = 15;
  localparam int PB_EN   = 14;
  localparam int PA_VAL  = 13;
  localparam int PB_VAL  = 12;
  localparam int CLS_HI  = 11;
  localparam int CLS_LO  = 8;
  localparam int B_REL   = 7;
  localparam int B_PUSH  = 6;
  localparam int B_POP   = 5;
  localparam int B_SWI   = 4;
  localparam int B_IEWR  = 3;
  localparam int B_IEVAL = 2;
  localparam logic [3:0] CLS_CTL = 4'h4;

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
#(
  parameter int IW   = 16,
  parameter int RIDX = 5
) (
  input  logic [IW-1:0]   word_a,
  input  logic [IW-1:0]   word_b,
  input  logic [1:0]      flag_q,
  output ctl_dec_t        dec,
  output logic [RIDX-1:0] src_idx
);

  logic miss_a, miss_b;
  logic unused_bits;

  assign miss_a = word_a[PA_EN] & (word_a[PA_VAL] != flag_q[0]);
  assign miss_b = word_a[PB_EN] & (word_a[PB_VAL] != flag_q[1]);

  always_comb begin
    dec.skip   = miss_a | miss_b;
    dec.is_ctl = (word_a[CLS_HI:CLS_LO] == CLS_CTL);
    dec.rel    = word_a[B_REL];
    dec.push   = word_a[B_PUSH];
    dec.pop    = word_a[B_POP];
    dec.swi    = word_a[B_SWI];
    dec.ie_wr  = word_a[B_IEWR];
    dec.ie_val = word_a[B_IEVAL];
  end

  assign src_idx     = word_b[IW-1 -: RIDX];
  assign unused_bits = ^{word_a[1:0], word_b[IW-RIDX-1:0]};

endmodule

// File: rtl/bsu_flags.sv
module bsu_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] wr_en,
  input  logic [NFLAG-1:0] wr_val,
  output logic [NFLAG-1:0] flag_q
);

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (wr_en[g]) begin
        bit_q <= wr_val[g];
      end
    end
    assign flag_q[g] = bit_q;

    // R2
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[g] |=> (flag_q[g] == $past(wr_val[g])));

    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en[g] |=> $stable(flag_q[g]));
  end

endmodule

// File: rtl/bsu_seq.sv
module bsu_seq
  import bsu_pkg::*;
#(
  parameter int DW   = 16,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  ctl_dec_t        dec,
  input  logic [RIDX-1:0] src_idx,
  input  logic [DW-1:0]   rf_val,
  output logic            mem_req,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            done,
  output logic            idle,
  output logic [DW-1:0]   pc,
  output logic [DW-1:0]   sp,
  output logic            int_en
);

  localparam logic [RIDX-1:0] PC_SEL = RIDX'((2 ** RIDX) - 1);
  localparam logic [RIDX-1:0] SP_SEL = RIDX'((2 ** RIDX) - 2);
  localparam logic [DW-1:0]   STEP   = DW'(2);
  localparam logic [DW-1:0]   ONE    = DW'(1);

  seq_state_t    state_q, state_d;
  logic [DW-1:0] pc_q, pc_d, sp_q, sp_d, tgt_q, tgt_d;
  logic          ie_q, ie_d;
  ctl_dec_t      op_q, op_d;
  logic [DW-1:0] src_val;
  logic          pc_en, sp_en, ie_en, tgt_en, op_en;

  always_comb begin
    if (src_idx == PC_SEL) begin
      src_val = pc_q;
    end else if (src_idx == SP_SEL) begin
      src_val = sp_q;
    end else begin
      src_val = rf_val;
    end
  end

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    sp_d      = sp_q;
    ie_d      = ie_q;
    tgt_d     = tgt_q;
    op_d      = op_q;
    pc_en     = 1'b0;
    sp_en     = 1'b0;
    ie_en     = 1'b0;
    tgt_en    = 1'b0;
    op_en     = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          tgt_en = 1'b1;
          op_en  = 1'b1;
          op_d   = dec;
          if (dec.skip || !dec.is_ctl) begin
            tgt_d       = pc_q + STEP;
            op_d.rel    = 1'b0;
            op_d.ie_wr  = 1'b0;
            state_d     = ST_COMMIT;
          end else if (dec.swi && ie_q) begin
            tgt_d    = '0;
            op_d.rel = 1'b0;
            op_d.pop = 1'b0;
            state_d  = dec.push ? ST_PUSH : ST_COMMIT;
          end else begin
            tgt_d   = src_val;
            state_d = dec.pop ? ST_POP_REQ : (dec.push ? ST_PUSH : ST_COMMIT);
          end
        end
      end
      ST_POP_REQ: begin
        mem_req  = 1'b1;
        mem_addr = sp_q + ONE;
        sp_en    = 1'b1;
        sp_d     = sp_q + ONE;
        state_d  = ST_POP_CAP;
      end
      ST_POP_CAP: begin
        tgt_en  = 1'b1;
        tgt_d   = mem_rdata;
        state_d = op_q.push ? ST_PUSH : ST_COMMIT;
      end
      ST_PUSH: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q;
        mem_wdata = pc_q + STEP;
        sp_en     = 1'b1;
        sp_d      = sp_q - ONE;
        state_d   = ST_COMMIT;
      end
      ST_COMMIT: begin
        pc_en   = 1'b1;
        pc_d    = op_q.rel ? (pc_q + tgt_q) : tgt_q;
        ie_en   = op_q.ie_wr;
        ie_d    = op_q.ie_val;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      sp_q    <= '0;
      ie_q    <= 1'b0;
      tgt_q   <= '0;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en)  pc_q  <= pc_d;
      if (sp_en)  sp_q  <= sp_d;
      if (ie_en)  ie_q  <= ie_d;
      if (tgt_en) tgt_q <= tgt_d;
      if (op_en)  op_q  <= op_d;
    end
  end

  assign done   = (state_q == ST_COMMIT);
  assign idle   = (state_q == ST_IDLE);
  assign pc     = pc_q;
  assign sp     = sp_q;
  assign int_en = ie_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  push_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> done);

  // R7
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (sp == ($past(mem_addr) - ONE)));

  // R8
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (sp == $past(mem_addr)));

  // R8
  pop_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req);

  // R11
  pc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(pc));

  // R10
  ie_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(int_en));

endmodule

// File: rtl/branch_stack_unit.sv
module branch_stack_unit
  import bsu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int IW    = 16,
  parameter int RIDX  = 5,
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IW-1:0]    instr_hi,
  input  logic [IW-1:0]    instr_lo,
  output logic [RIDX-1:0]  rf_sel,
  input  logic [DW-1:0]    rf_val,
  input  logic [NFLAG-1:0] flag_we,
  input  logic [NFLAG-1:0] flag_wd,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             done,
  output logic [DW-1:0]    pc,
  output logic [DW-1:0]    sp,
  output logic [NFLAG-1:0] flags,
  output logic             int_en
);

  logic     rst_meta, rst_sync;
  ctl_dec_t dec;
  logic     idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bsu_flags #(.NFLAG(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync),
    .wr_en  (flag_we),
    .wr_val (flag_wd),
    .flag_q (flags)
  );

  bsu_decode #(.IW(IW), .RIDX(RIDX)) u_dec (
    .word_a  (instr_hi),
    .word_b  (instr_lo),
    .flag_q  (flags[1:0]),
    .dec     (dec),
    .src_idx (rf_sel)
  );

  bsu_seq #(.DW(DW), .RIDX(RIDX)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync),
    .start     (start),
    .dec       (dec),
    .src_idx   (rf_sel),
    .rf_val    (rf_val),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .done      (done),
    .idle      (idle),
    .pc        (pc),
    .sp        (sp),
    .int_en    (int_en)
  );

  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (start && idle && dec.skip) |=> (done && !mem_req));

  // R4
  other_class_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (start && idle && !dec.is_ctl) |=> (done && !mem_req));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync |-> (!mem_req && !done));

endmodule

// File: tb/tb_branch_stack_unit.sv
module tb_branch_stack_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr_hi = '0;
  logic [15:0] instr_lo = '0;
  logic [4:0]  rf_sel;
  logic [15:0] rf_val;
  logic [1:0]  flag_we = '0;
  logic [1:0]  flag_wd = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        done;
  logic [15:0] pc, sp;
  logic [1:0]  flags;
  logic        int_en;

  int checks = 0;
  int errors = 0;
  int acc_cnt = 0;
  int cyc_total = 0;

  logic [15:0] mem  [256];
  logic [15:0] regs [32];
  logic [15:0] m_pc = '0, m_sp = '0;
  logic        m_fa = 1'b0, m_fb = 1'b0, m_ie = 1'b0;

  always #4 clk = ~clk;

  branch_stack_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_hi(instr_hi), .instr_lo(instr_lo),
    .rf_sel(rf_sel), .rf_val(rf_val), .flag_we(flag_we), .flag_wd(flag_wd),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .pc(pc), .sp(sp), .flags(flags), .int_en(int_en)
  );

  assign rf_val = regs[rf_sel];

  always @(posedge clk) begin
    if (mem_req) begin
      acc_cnt = acc_cnt + 1;
      if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
      else mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  always @(posedge clk) begin
    cyc_total = cyc_total + 1;
    if (cyc_total == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc_total);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_flags(input logic [1:0] we, input logic [1:0] wd);
    @(negedge clk);
    flag_we = we;
    flag_wd = wd;
    @(negedge clk);
    flag_we = '0;
    if (we[0]) m_fa = wd[0];
    if (we[1]) m_fb = wd[1];
    chk("R2", "flags", {30'd0, flags}, {30'd0, m_fb, m_fa});
  endtask

  task automatic run_instr(input logic [15:0] w0, input logic [15:0] w1, input string req);
    logic [15:0] e_pc, e_sp, tgt, push_addr, push_val;
    logic        e_ie, skp, cf, do_push, do_pop;
    logic [4:0]  idx;
    int          lat, n;
    skp = (w0[15] && (w0[13] != m_fa)) || (w0[14] && (w0[12] != m_fb));
    cf = (w0[11:8] == 4'h4);
    e_pc = m_pc; e_sp = m_sp; e_ie = m_ie;
    do_push = 1'b0; do_pop = 1'b0; push_addr = '0; push_val = '0; tgt = '0;
    if (skp || !cf) begin
      e_pc = m_pc + 16'd2;
    end else if (w0[4] && m_ie) begin
      do_push = w0[6];
      if (do_push) begin
        push_addr = e_sp; push_val = m_pc + 16'd2; e_sp = e_sp - 16'd1;
      end
      e_pc = '0;
      if (w0[3]) e_ie = w0[2];
    end else begin
      do_pop = w0[5];
      if (do_pop) begin
        e_sp = e_sp + 16'd1;
        tgt = mem[e_sp[7:0]];
      end else begin
        idx = w1[15:11];
        tgt = (idx == 5'd31) ? m_pc : ((idx == 5'd30) ? m_sp : regs[idx]);
      end
      do_push = w0[6];
      if (do_push) begin
        push_addr = e_sp; push_val = m_pc + 16'd2; e_sp = e_sp - 16'd1;
      end
      e_pc = w0[7] ? (m_pc + tgt) : tgt;
      if (w0[3]) e_ie = w0[2];
    end
    lat = 1 + (do_pop ? 2 : 0) + (do_push ? 1 : 0);
    @(negedge clk);
    instr_hi = w0;
    instr_lo = w1;
    start = 1'b1;
    acc_cnt = 0;
    n = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      n = n + 1;
    end while (!done && n < 20);
    chk("R11", "latency", n, lat);
    chk(req, "accesses", acc_cnt, (do_pop ? 1 : 0) + (do_push ? 1 : 0));
    @(negedge clk);
    chk("R11", "done width", {31'd0, done}, 32'd0);
    chk(req, "pc", {16'd0, pc}, {16'd0, e_pc});
    chk(req, "sp", {16'd0, sp}, {16'd0, e_sp});
    chk(req, "int_en", {31'd0, int_en}, {31'd0, e_ie});
    if (do_push) chk("R7", "pushed word", {16'd0, mem[push_addr[7:0]]}, {16'd0, push_val});
    m_pc = e_pc; m_sp = e_sp; m_ie = e_ie;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    for (int i = 0; i < 32; i++) regs[i] = 16'($urandom);
    regs[5] = 16'h1234;
    regs[7] = 16'hFFF0;
    repeat (3) @(negedge clk);
    // R1: reset held
    chk("R1", "pc in reset", {16'd0, pc}, 32'd0);
    chk("R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "pc", {16'd0, pc}, 32'd0);
    chk("R1", "sp", {16'd0, sp}, 32'd0);
    chk("R1", "flags", {30'd0, flags}, 32'd0);
    chk("R1", "int_en", {31'd0, int_en}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);

    // R2: independent flag writes
    set_flags(2'b01, 2'b01);
    set_flags(2'b10, 2'b10);
    set_flags(2'b01, 2'b10);

    // R4: other instruction classes
    run_instr(16'h0100, 16'hFFFF, "R4");
    run_instr(16'h0EFF, 16'h0000, "R4");
    // R3: A=0, B=1 now; A must be 1 -> skipped push/jump
    run_instr(16'hA4C0, 16'h2800, "R3");
    // R3: B must be 0 -> skipped
    run_instr(16'h4460, 16'h2800, "R3");
    // R3: B must be 1 -> taken absolute jump to regs[5]
    run_instr(16'h5400, 16'h2800, "R3");
    // R5: register 31 relative (pc doubles), register 30 absolute
    run_instr(16'h0480, 16'hF800, "R5");
    run_instr(16'h0400, 16'hF000, "R5");
    run_instr(16'h0400, 16'h2800, "R5");
    // R6: relative wrap 0x1234 + 0xFFF0
    run_instr(16'h0480, 16'h3800, "R6");
    // R7: push with absolute jump
    run_instr(16'h0440, 16'h2800, "R7");
    run_instr(16'h0440, 16'h3800, "R7");
    // R8: pop, then pop with push together
    run_instr(16'h0420, 16'h0000, "R8");
    run_instr(16'h0460, 16'h0000, "R8");
    run_instr(16'h04A0, 16'h0000, "R8");
    // R9: interrupt bit with enable off acts as normal jump
    run_instr(16'h0410, 16'h2800, "R9");
    // R10: set enable on a jump
    run_instr(16'h040C, 16'h2800, "R10");
    // R9: interrupt with push, pop/relative ignored
    run_instr(16'h04F0, 16'h3800, "R9");
    run_instr(16'h0490, 16'h3800, "R9");
    // R10: interrupt clears enable
    run_instr(16'h0418, 16'h2800, "R10");
    run_instr(16'h0410, 16'h2800, "R9");

    for (int k = 0; k < 400; k++) begin
      logic [15:0] w0, w1;
      if (($urandom % 5) == 0) set_flags(2'($urandom), 2'($urandom));
      w0 = 16'($urandom);
      w1 = 16'($urandom);
      if (($urandom % 4) != 0) w0[11:8] = 4'h4;
      run_instr(w0, w1, "R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule